// File: doc/BRIEF.md
# Bit-Band Alias Address Remapper

This unit sits on the path between one bus master and a 32-bit memory. It splits the address space into two kinds of access. Ordinary accesses go straight through. Accesses that land in the alias window are remapped. Each word-aligned alias address stands for exactly one bit of a smaller bit-band window. The 32 consecutive alias words belong to one target word.

An alias read returns the selected bit as 0 or 1 in bit 0 of the read data, in the same cycle. An alias write becomes an indivisible read-modify-write of the computed target word. In the first cycle the unit reads the word with the memory lock raised and holds the master with ready low. In the second cycle it writes back the word with only the selected bit changed. The lock is still raised during that write.

Software can therefore set or clear a single flag with one store. It needs no mask sequence and no exclusive-access loop.

Top module: `bitband_remap`

## Requirements
- R1: When an access falls outside the alias window, the memory sees the master's request, write flag, address and write data unchanged in the same cycle. The master sees the memory read data, ready stays high and the lock stays low.
- R2: The alias window starts at 0x22000000 and is 32 times the bit-band window size (default 1 MiB). Let the alias offset be the address minus 0x22000000. The target word address is 0x20000000 + (offset / 128) * 4, and the bit index is (offset / 4) mod 32.
- R3: An alias read completes in the cycle it is presented. It returns the target bit in bit 0, with bits 31:1 at zero.
- R4: An alias write whose write data bit 0 is 1 sets the target bit and leaves the other 31 bits of the target word unchanged.
- R5: An alias write whose write data bit 0 is 0 clears the target bit. Write data bits 31:1 have no effect.
- R6: An alias write holds ready low for exactly one cycle and completes with ready high in the following cycle.
- R7: During an alias write the lock is high in both the read cycle and the write-back cycle, and both cycles address the same target word. The lock is low for every other access.
- R8: While reset is asserted and after reset with no request, ready is high and the memory request and lock are low.
- R9: Back-to-back alias writes to different bits of the same word both take effect.
- R10: The last alias word of the window maps to bit 31 of the last bit-band word. The word just below the alias base and the first word above the alias window pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_req | input | 1 | Master request, held until ready |
| m_we | input | 1 | Master write flag |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Read data to master |
| m_ready | output | 1 | Access completes in this cycle when high |
| s_req | output | 1 | Memory request |
| s_we | output | 1 | Memory write flag |
| s_addr | output | 32 | Memory byte address |
| s_wdata | output | 32 | Memory write data |
| s_rdata | input | 32 | Memory read data, valid in the same cycle as s_addr |
| s_lock | output | 1 | Memory lock, keeps other masters off the target word |

## Verification
Pass-through accesses and alias reads return their results in the cycle they are presented. The bench samples ready, read data, the memory address and the lock mid-way through the low clock phase of that same cycle. An alias write shows ready low in its first cycle and ready high, with the merged word on the memory write data, in the second cycle. The bench samples each of those two cycles, counts the stall cycles, and compares both against the expected count of one. The memory contents change at the rising edge that ends the write-back cycle, so contents are checked only through later reads.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

   // Two-phase sequencer for alias writes: the fetch happens while idle,
   // the write-back happens in the store state.
   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_STORE = 1'b1
   } seq_state_e;

   // Routing choice of the front end in one cycle.
   typedef enum logic [1:0] {
      ROUTE_PASS  = 2'd0,
      ROUTE_ARD   = 2'd1,
      ROUTE_FETCH = 2'd2,
      ROUTE_STORE = 2'd3
   } route_e;

   function automatic int unsigned log2_exact(input longint unsigned v);
      int unsigned n;
      n = 0;
      while ((longint'(1) << n) < v) n++;
      return n;
   endfunction

endpackage

// File: rtl/bbr_decode.sv
module bbr_decode #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'(32'h2200_0000),
   parameter logic [ADDR_W-1:0] BB_BASE    = ADDR_W'(32'h2000_0000),
   parameter longint unsigned   BB_BYTES   = 64'h10_0000
) (
   input  logic [ADDR_W-1:0]         addr,
   output logic                      hit,
   output logic [ADDR_W-1:0]         target,
   output logic [$clog2(DATA_W)-1:0] bit_idx
);
   localparam int unsigned BYTE_SH = $clog2(DATA_W / 8);
   localparam int unsigned BIT_W   = $clog2(DATA_W);
   localparam int unsigned WORD_SH = BYTE_SH + BIT_W;
   localparam longint unsigned ALIAS_SPAN = BB_BYTES * longint'(DATA_W);

   logic [ADDR_W-1:0] offset;
   logic              above_base;
   logic              inside_span;

   always_comb begin
      offset      = addr - ALIAS_BASE;
      above_base  = (addr >= ALIAS_BASE);
      inside_span = (64'(offset) < ALIAS_SPAN);
      hit         = above_base && inside_span;
      target      = BB_BASE + ((offset >> WORD_SH) << BYTE_SH);
      bit_idx     = offset[BYTE_SH +: BIT_W];
   end

endmodule

// File: rtl/bbr_bitops.sv
module bbr_bitops #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]         word,
   input  logic [$clog2(DATA_W)-1:0] bit_idx,
   input  logic                      val,
   output logic [DATA_W-1:0]         merged,
   output logic                      picked
);
   localparam int unsigned BIT_W = $clog2(DATA_W);

   // One replace-mux per bit lane; only the selected lane takes val.
   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      assign merged[i] = (bit_idx == BIT_W'(i)) ? val : word[i];
   end

   assign picked = word[bit_idx];

endmodule

// File: rtl/bbr_rmw_seq.sv
module bbr_rmw_seq
   import bbr_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] target_in,
   input  logic [DATA_W-1:0] merged_in,
   output logic              busy,
   output logic [ADDR_W-1:0] hold_addr,
   output logic [DATA_W-1:0] hold_word
);
   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE:  if (start) state_d = SEQ_STORE;
         SEQ_STORE: state_d = SEQ_IDLE;
         default:   state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         hold_addr <= '0;
         hold_word <= '0;
      end else begin
         state_q <= state_d;
         if (start && state_q == SEQ_IDLE) begin
            hold_addr <= target_in;
            hold_word <= merged_in;
         end
      end
   end

   assign busy = (state_q == SEQ_STORE);

   AST_STORE_IS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy) else $error("store phase lasted more than one cycle"); // R6

endmodule

// File: rtl/bitband_remap.sv
module bitband_remap
   import bbr_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'(32'h2200_0000),
   parameter logic [ADDR_W-1:0] BB_BASE    = ADDR_W'(32'h2000_0000),
   parameter longint unsigned   BB_BYTES   = 64'h10_0000,
   parameter bit                LOCK_ALIAS_READ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_req,
   input  logic              m_we,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [DATA_W-1:0] m_wdata,
   output logic [DATA_W-1:0] m_rdata,
   output logic              m_ready,
   output logic              s_req,
   output logic              s_we,
   output logic [ADDR_W-1:0] s_addr,
   output logic [DATA_W-1:0] s_wdata,
   input  logic [DATA_W-1:0] s_rdata,
   output logic              s_lock
);
   localparam int unsigned BIT_W = $clog2(DATA_W);
   localparam longint unsigned ALIAS_SPAN = BB_BYTES * longint'(DATA_W);

   // Elaboration-time parameter checks
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power of two of at least 8");
   end
   if (BB_BYTES == 0 || (BB_BYTES & (BB_BYTES - 1)) != 0) begin : g_bad_bb_bytes
      $error("BB_BYTES must be a non-zero power of two");
   end
   if (64'(ALIAS_BASE) + ALIAS_SPAN > (longint'(1) << ADDR_W)) begin : g_bad_span
      $error("alias window exceeds the address space");
   end
   if (log2_exact(BB_BYTES) + BIT_W > ADDR_W) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the alias window");
   end

   logic              alias_hit;
   logic [ADDR_W-1:0] tgt_addr;
   logic [BIT_W-1:0]  tgt_bit;
   logic [DATA_W-1:0] merged_word;
   logic              picked_bit;
   logic              busy;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_word;
   logic              start_rmw;
   logic              rd_lock;
   route_e            route;

   bbr_decode #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .ALIAS_BASE (ALIAS_BASE),
      .BB_BASE    (BB_BASE),
      .BB_BYTES   (BB_BYTES)
   ) decode_i (
      .addr    (m_addr),
      .hit     (alias_hit),
      .target  (tgt_addr),
      .bit_idx (tgt_bit)
   );

   bbr_bitops #(
      .DATA_W (DATA_W)
   ) bitops_i (
      .word    (s_rdata),
      .bit_idx (tgt_bit),
      .val     (m_wdata[0]),
      .merged  (merged_word),
      .picked  (picked_bit)
   );

   bbr_rmw_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_rmw),
      .target_in (tgt_addr),
      .merged_in (merged_word),
      .busy      (busy),
      .hold_addr (hold_addr),
      .hold_word (hold_word)
   );

   // Variant: alias reads may also raise the lock for their single cycle.
   if (LOCK_ALIAS_READ) begin : g_read_locked
      assign rd_lock = 1'b1;
   end else begin : g_read_open
      assign rd_lock = 1'b0;
   end

   always_comb begin
      if (busy)                       route = ROUTE_STORE;
      else if (m_req && alias_hit)    route = m_we ? ROUTE_FETCH : ROUTE_ARD;
      else                            route = ROUTE_PASS;
   end

   assign start_rmw = (route == ROUTE_FETCH);

   always_comb begin
      s_req   = m_req;
      s_we    = m_we;
      s_addr  = m_addr;
      s_wdata = m_wdata;
      s_lock  = 1'b0;
      m_ready = 1'b1;
      m_rdata = s_rdata;
      unique case (route)
         ROUTE_STORE: begin
            s_req   = 1'b1;
            s_we    = 1'b1;
            s_addr  = hold_addr;
            s_wdata = hold_word;
            s_lock  = 1'b1;
            m_rdata = '0;
         end
         ROUTE_FETCH: begin
            s_req   = 1'b1;
            s_we    = 1'b0;
            s_addr  = tgt_addr;
            s_wdata = '0;
            s_lock  = 1'b1;
            m_ready = 1'b0;
            m_rdata = '0;
         end
         ROUTE_ARD: begin
            s_req   = 1'b1;
            s_we    = 1'b0;
            s_addr  = tgt_addr;
            s_wdata = '0;
            s_lock  = rd_lock;
            m_rdata = {{(DATA_W-1){1'b0}}, picked_bit};
         end
         default: begin
         end
      endcase
   end

   // Assertions beside the routing they guard
   AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ready) |=> m_ready) else $error("stall longer than one cycle"); // R6

   AST_FETCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ready) |-> (s_req && !s_we && s_lock)) else $error("fetch not locked"); // R7

   AST_STORE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ready) |=> (s_req && s_we && s_lock && $stable(s_addr)))
      else $error("write-back not locked or moved"); // R7

   AST_ONE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req && s_we && s_lock) |-> ($countones(s_wdata ^ $past(s_rdata)) <= 1))
      else $error("write-back changed more than one bit"); // R4

   AST_ALIAS_READ_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_we && alias_hit && !busy) |-> (m_rdata[DATA_W-1:1] == '0))
      else $error("alias read upper bits not zero"); // R3

   AST_PASS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !alias_hit && !busy) |-> (!s_lock && m_ready && s_addr == m_addr))
      else $error("pass-through access altered"); // R1

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_req && !busy) |-> (!s_req && !s_lock && m_ready))
      else $error("idle bus not quiet"); // R8

endmodule

// File: tb/bitband_remap_tb_top.sv
module bitband_remap_tb_top;
   localparam logic [31:0] ABASE = 32'h2200_0000;
   localparam logic [31:0] BBASE = 32'h2000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_req = 1'b0;
   logic        m_we = 1'b0;
   logic [31:0] m_addr = '0;
   logic [31:0] m_wdata = '0;
   logic [31:0] m_rdata;
   logic        m_ready;
   logic        s_req;
   logic        s_we;
   logic [31:0] s_addr;
   logic [31:0] s_wdata;
   logic [31:0] s_rdata;
   logic        s_lock;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] mem  [0:255];
   logic [31:0] refm [0:255];

   always #10 clk = ~clk;   // 50 MHz

   bitband_remap dut_i (
      .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
      .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .s_req(s_req),
      .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .s_lock(s_lock)
   );

   function automatic logic [7:0] midx(input logic [31:0] a);
      return {a[26], a[24], a[7:2]};
   endfunction

   assign s_rdata = mem[midx(s_addr)];

   always @(posedge clk) if (s_req && s_we) mem[midx(s_addr)] <= s_wdata;

   function automatic logic is_alias(input logic [31:0] a);
      return (a >= ABASE) && (a - ABASE < 32'h0200_0000);
   endfunction
   function automatic logic [31:0] tgt_of(input logic [31:0] a);
      return BBASE + (((a - ABASE) >> 7) << 2);
   endfunction
   function automatic int bit_of(input logic [31:0] a);
      return int'((a >> 2) & 32'd31);
   endfunction
   function automatic logic [31:0] alias_of(input int w, input int b);
      return ABASE + 32'(w * 128 + b * 4);
   endfunction

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One master access; samples mid-low-phase of each cycle it spans.
   task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                         output logic [31:0] rd);
      int stalls;
      logic al;
      logic [31:0] t, expw;
      al = is_alias(addr);
      t = tgt_of(addr);
      stalls = 0;
      rd = '0;
      @(negedge clk);
      m_req = 1'b1; m_we = we; m_addr = addr; m_wdata = wd;
      forever begin
         #5;
         if (al && we) begin
            check(s_lock === 1'b1, "R7 lock", {31'b0, s_lock}, 32'd1);
            check(s_addr === t, "R2 target", s_addr, t);
            if (stalls == 1) begin
               expw = refm[midx(t)];
               expw[bit_of(addr)] = wd[0];
               check(s_we === 1'b1 && s_wdata === expw, "R4/R5 merged word", s_wdata, expw);
            end
         end else if (al) begin
            check(s_addr === t && s_lock === 1'b0, "R2 read target", s_addr, t);
         end else begin
            check(s_addr === addr && s_lock === 1'b0 && s_we === we && s_wdata === wd,
                  "R1 pass", s_addr, addr);
         end
         if (m_ready === 1'b1) begin
            rd = m_rdata;
            break;
         end
         stalls++;
         if (stalls > 3) break;
         @(negedge clk);
      end
      check(stalls == ((al && we) ? 1 : 0), "R6 stall count", 32'(stalls),
            (al && we) ? 32'd1 : 32'd0);
      @(posedge clk);
      #1;
      m_req = 1'b0; m_we = 1'b0;
      if (we) begin
         if (al) refm[midx(t)][bit_of(addr)] = wd[0];
         else    refm[midx(addr)] = wd;
      end
   endtask

   task automatic expect_read(input logic [31:0] addr, input string req);
      logic [31:0] rd, exp;
      access(1'b0, addr, 32'h0, rd);
      if (is_alias(addr)) exp = {31'b0, refm[midx(tgt_of(addr))][bit_of(addr)]};
      else                exp = refm[midx(addr)];
      check(rd === exp, req, rd, exp);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         finish_run();
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) begin mem[i] = '0; refm[i] = '0; end

      // R8: reset state
      repeat (3) @(negedge clk);
      #5;
      check(m_ready === 1'b1 && s_req === 1'b0 && s_lock === 1'b0, "R8 in reset",
            {29'b0, m_ready, s_req, s_lock}, 32'h4);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #5;
      check(m_ready === 1'b1 && s_req === 1'b0 && s_lock === 1'b0, "R8 after reset",
            {29'b0, m_ready, s_req, s_lock}, 32'h4);

      // R1: fill bit-band words by plain writes, read back
      for (int w = 0; w < 16; w++) access(1'b1, BBASE + 32'(w * 4), $urandom, rd);
      for (int w = 0; w < 16; w++) expect_read(BBASE + 32'(w * 4), "R1 readback");

      // R3: alias reads of every bit of word 3
      for (int b = 0; b < 32; b++) expect_read(alias_of(3, b), "R3 alias read");

      // R4/R5: set with 1, clear with upper bits set
      access(1'b1, 32'h2000_0014, 32'h0000_0000, rd);
      access(1'b1, alias_of(5, 17), 32'h0000_0001, rd);
      expect_read(32'h2000_0014, "R4 set bit");
      access(1'b1, 32'h2000_0018, 32'hFFFF_FFFF, rd);
      access(1'b1, alias_of(6, 0), 32'hFFFF_FFFE, rd);
      expect_read(32'h2000_0018, "R5 clear ignores upper data");
      access(1'b1, alias_of(6, 31), 32'h0000_0002, rd);
      expect_read(32'h2000_0018, "R5 clear bit 31");

      // R9: back-to-back alias writes to one word
      access(1'b1, 32'h2000_001C, 32'h0, rd);
      access(1'b1, alias_of(7, 2), 32'h1, rd);
      access(1'b1, alias_of(7, 9), 32'h1, rd);
      access(1'b1, alias_of(7, 30), 32'h1, rd);
      expect_read(32'h2000_001C, "R9 back-to-back");

      // R10: window edges
      access(1'b1, 32'h200F_FFFC, 32'h0, rd);
      access(1'b1, 32'h23FF_FFFC, 32'h1, rd);
      expect_read(32'h200F_FFFC, "R10 last alias word");
      expect_read(32'h23FF_FFFC, "R10 last alias read");
      access(1'b1, 32'h21FF_FFFC, 32'hA5A5_5A5A, rd);
      expect_read(32'h21FF_FFFC, "R10 below base passes");
      access(1'b1, 32'h2400_0000, 32'h1234_5678, rd);
      expect_read(32'h2400_0000, "R10 above window passes");

      // Random mix against the bench model
      for (int n = 0; n < 400; n++) begin
         int w, b, kind;
         w = int'($urandom_range(15, 0));
         b = int'($urandom_range(31, 0));
         kind = int'($urandom_range(3, 0));
         case (kind)
            0: access(1'b1, alias_of(w, b), $urandom, rd);
            1: expect_read(alias_of(w, b), "R3 random alias read");
            2: expect_read(BBASE + 32'(w * 4), "R4 random word read");
            default: if (b < 4) access(1'b1, BBASE + 32'(w * 4), $urandom, rd);
                     else expect_read(BBASE + 32'(w * 4), "R1 random read");
         endcase
      end
      for (int w = 0; w < 16; w++) expect_read(BBASE + 32'(w * 4), "R4 final sweep");

      done = 1'b1;
      finish_run();
   end

endmodule